// File: doc/BRIEF.md
# Variable-Length Bit-Field Shifter

This execution unit takes a 64-bit word and treats its low `len` bits as a field. It shifts that field right or left by `cnt` positions and fills the vacated positions with zeros. Bits above the field are copied through unchanged. Both the field length and the shift count are set at run time. The count wraps modulo the field length. A zero field length or a zero count makes the request do nothing. A carry flag holds the last bit that left the field.

Each shift is one registered step. In level mode the unit executes on every cycle that `start` is high. In edge mode it executes once for each rising edge of `start`. The result, the carry and a one-cycle `done` pulse appear on the clock after the triggering edge, and they hold until the next executed shift.

Top module: `var_bitfield_shifter`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first executed shift, `dout`, `carry` and `done` are 0.
- R2: With `dir_left`=0 (right), field bit i+e moves to bit i, and the top e field bits become 0. `carry` takes `din[e-1]`. Here n = min(`len`,64) and e = `cnt` mod n.
- R3: With `dir_left`=1 (left), field bit i moves to bit i+e. Bits that would pass bit n-1 are lost, and the low e bits become 0. `carry` takes `din[n-e]`.
- R4: Bits n to 63 of `dout` equal the same bits of `din` on every executed shift.
- R5: When `cnt` is not 0 and e is 0, `dout` equals `din`, `carry` is 0, and `done` still pulses.
- R6: A `len` above 64 behaves exactly as `len`=64.
- R7: When `len`=0 or `cnt`=0, nothing executes: `dout` and `carry` keep their values and `done` stays 0.
- R8: With `pulse_mode`=0, every cycle with `start` high and non-zero operands executes a shift.
- R9: With `pulse_mode`=1, a shift executes only on a cycle where `start` is high and was low on the previous cycle. Holding `start` high causes no further shifts.
- R10: `dout` and `carry` update, and `done` is high for exactly one cycle, on the clock after the triggering edge. `done` is never high without a trigger in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 64 | Source word; the low n bits form the field |
| len | input | 16 | Field length, unsigned; values above 64 are clamped to 64 |
| cnt | input | 16 | Shift count, unsigned; wraps modulo the field length |
| dir_left | input | 1 | 1 = shift toward the field top, 0 = shift toward bit 0 |
| start | input | 1 | Execution request |
| pulse_mode | input | 1 | 1 = execute on the rising edge of start, 0 = execute while start is high |
| dout | output | 64 | Shifted word |
| carry | output | 1 | Last bit shifted out of the field |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Every result is due on the clock after the trigger edge. The bench drives operands and `start` on the falling edge. It samples `dout`, `carry` and `done` one time unit after the next rising edge, while those inputs are still applied. In the idle cycle between requests it checks that `done` is low and that the outputs hold. For held-`start` sequences it samples after each rising edge, which shows one result per cycle in level mode and a single result in edge mode.

// File: rtl/var_bitfield_shifter.sv
module var_bitfield_shifter #(
  parameter int W  = 64,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [OW-1:0] len,
  input  logic [OW-1:0] cnt,
  input  logic          dir_left,
  input  logic          start,
  input  logic          pulse_mode,
  output logic [W-1:0]  dout,
  output logic          carry,
  output logic          done
);
  localparam int NW = $clog2(W + 1);

  logic          start_q;
  logic          trig;
  logic [NW-1:0] n;
  logic [NW-1:0] n_div;
  logic [OW-1:0] rem;
  logic [NW-1:0] eff;
  logic          go;
  logic [W-1:0]  res;
  logic          cy;

  assign trig  = pulse_mode ? (start & ~start_q) : start;
  assign n     = (len > OW'(W)) ? NW'(W) : len[NW-1:0];
  assign n_div = (n == '0) ? NW'(1) : n;
  assign rem   = cnt % OW'(n_div);
  assign eff   = rem[NW-1:0];
  assign go    = trig && (n != '0) && (cnt != '0);

  always_comb begin
    int ni;
    int ei;
    ni  = int'(n);
    ei  = int'(eff);
    res = din;
    cy  = 1'b0;
    if (ei != 0) begin
      for (int i = 0; i < W; i++) begin
        if (i < ni) begin
          if (!dir_left)
            res[i] = (i + ei < ni) ? din[i + ei] : 1'b0;
          else
            res[i] = (i >= ei) ? din[i - ei] : 1'b0;
        end
      end
      cy = dir_left ? din[ni - ei] : din[ei - 1];
    end
  end

  always_ff @(posedge clk) begin
    start_q <= start;
    if (!rst_n) begin
      dout <= '0;
      carry <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= go;
      if (go) begin
        dout  <= res;
        carry <= cy;
      end
    end
  end
endmodule

module var_bitfield_shifter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] din,
  input logic [15:0] len,
  input logic [15:0] cnt,
  input logic        start,
  input logic        pulse_mode,
  input logic [63:0] dout,
  input logic        carry,
  input logic        done
);
  function automatic logic [63:0] field_mask(input logic [15:0] l);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < int'(l)) m[i] = 1'b1;
    return m;
  endfunction

  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start)); // R10

  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(dout) && $stable(carry))); // R7

  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((dout & ~field_mask($past(len))) == ($past(din) & ~field_mask($past(len))))); // R4

  AST_LEVEL_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pulse_mode && len != 16'd0 && cnt != 16'd0) |=> done); // R8

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pulse_mode && $past(start)) |=> !done); // R9

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (len == 16'd0 || cnt == 16'd0) |=> !done); // R7
endmodule

bind var_bitfield_shifter var_bitfield_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .len(len), .cnt(cnt),
  .start(start), .pulse_mode(pulse_mode), .dout(dout),
  .carry(carry), .done(done)
);

// File: tb/var_bitfield_shifter_tb.sv
module var_bitfield_shifter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] din = '0;
  logic [15:0] len = '0;
  logic [15:0] cnt = '0;
  logic        dir_left = 1'b0;
  logic        start = 1'b0;
  logic        pulse_mode = 1'b0;
  logic [63:0] dout;
  logic        carry;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_dout = '0;
  logic        m_carry = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  var_bitfield_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .len(len), .cnt(cnt),
    .dir_left(dir_left), .start(start), .pulse_mode(pulse_mode),
    .dout(dout), .carry(carry), .done(done)
  );

  function automatic void model(input logic [63:0] d, input logic [15:0] l,
                                input logic [15:0] c, input logic left,
                                output logic [63:0] r, output logic cy);
    int n, e;
    logic [63:0] mask;
    n = (l > 16'd64) ? 64 : int'(l);
    e = int'(c) % n;
    mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    if (e == 0) begin
      r = d; cy = 1'b0;
    end else if (!left) begin
      r = (d & ~mask) | ((d & mask) >> e); cy = d[e-1];
    end else begin
      r = (d & ~mask) | (((d & mask) << e) & mask); cy = d[n-e];
    end
  endfunction

  task automatic check(input string req, input logic [63:0] ed, input logic ec, input logic edn);
    checks++;
    if (dout !== ed || carry !== ec || done !== edn) begin
      errors++;
      $display("FAIL %s dout=%h carry=%b done=%b expected dout=%h carry=%b done=%b",
               req, dout, carry, done, ed, ec, edn);
    end
  endtask

  task automatic run_op(input string req, input logic [63:0] d, input logic [15:0] l,
                        input logic [15:0] c, input logic left);
    logic [63:0] r;
    logic cy;
    @(negedge clk);
    din = d; len = l; cnt = c; dir_left = left; start = 1'b1;
    @(posedge clk); #1;
    if (l != 16'd0 && c != 16'd0) begin
      model(d, l, c, left, r, cy);
      m_dout = r; m_carry = cy;
      check(req, m_dout, m_carry, 1'b1);
    end else begin
      check(req, m_dout, m_carry, 1'b0);
    end
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    check("R10", m_dout, m_carry, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    logic cy;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1 check("R1", '0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1", '0, 1'b0, 1'b0);

    // R2 / R3 directed cases
    run_op("R2", 64'h0000_0000_0000_03F0, 16'd10, 16'd4, 1'b0);
    run_op("R3", 64'h0000_0000_0000_02DD, 16'd10, 16'd4, 1'b1);
    run_op("R2", 64'hFFFF_FFFF_FFFF_FFFF, 16'd64, 16'd63, 1'b0);
    run_op("R3", 64'h8000_0000_0000_0001, 16'd64, 16'd1, 1'b1);
    run_op("R4", 64'hDEAD_BEEF_0000_00FF, 16'd8, 16'd3, 1'b1);
    run_op("R5", 64'h1234_5678_9ABC_DEF0, 16'd16, 16'd48, 1'b0);
    run_op("R5", 64'h0000_0000_0000_0005, 16'd1, 16'd7, 1'b1);
    run_op("R6", 64'hF0F0_0000_0000_0001, 16'd500, 16'd65, 1'b1);
    run_op("R6", 64'hF0F0_0000_0000_0001, 16'hFFFF, 16'd2, 1'b0);
    run_op("R7", 64'hAAAA_AAAA_AAAA_AAAA, 16'd0, 16'd3, 1'b0);
    run_op("R7", 64'h5555_5555_5555_5555, 16'd20, 16'd0, 1'b1);
    run_op("R2", 64'h0000_0000_0000_0009, 16'd4, 16'd9, 1'b0);

    // R8: level mode, start held, new data each cycle
    pulse_mode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      din = {$urandom, $urandom}; len = 16'd40; cnt = 16'(k + 5); dir_left = k[0]; start = 1'b1;
      @(posedge clk); #1;
      model(din, len, cnt, dir_left, r, cy);
      m_dout = r; m_carry = cy;
      check("R8", m_dout, m_carry, 1'b1);
    end
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1 check("R10", m_dout, m_carry, 1'b0);

    // R9: pulse mode, start held, only the first cycle executes
    pulse_mode = 1'b1;
    @(negedge clk);
    din = 64'h0123_4567_89AB_CDEF; len = 16'd32; cnt = 16'd8; dir_left = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    model(din, len, cnt, dir_left, r, cy);
    m_dout = r; m_carry = cy;
    check("R9", m_dout, m_carry, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); din = {$urandom, $urandom}; cnt = 16'(k + 1);
      @(posedge clk); #1 check("R9", m_dout, m_carry, 1'b0);
    end
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1 check("R9", m_dout, m_carry, 1'b0);

    // random mix in both modes
    for (int k = 0; k < 400; k++) begin
      logic [15:0] l, c;
      pulse_mode = k[0];
      l = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 70);
      c = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 70);
      run_op(($urandom % 2 == 0) ? "R2" : "R3", {$urandom, $urandom}, l, c, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule